// File: doc/BRIEF.md
# Position Readout and Trigger Unit

This block sits between an interpolating position counter and a byte-wide host bus. Every clock it registers the incoming position word. When the active-low read strobe falls, it places the byte selected by the read address on an 8-bit output bus. The byte stays there until the next falling strobe.

The block also drives an active-low event output. Two enable bits choose what fires it. One source is any change of the registered position. The other is a transition into equality between the position and a programmable target. A comparison-depth field sets how many low bytes of the position take part in that comparison.

The event output can be wired back to the read strobe. Read address 0 is the power-up default and selects the low position byte. With the value-change enable preset at reset, every new position then shows up on the data lines with no host activity.

Top module: `pos_trig_unit`

## Requirements
- R1: While reset is held, `dout` is 0x00 and `evt_n` is 1. After reset, address 11 reads 0x05 (value-change and max-rate enables set, compare enable clear), address 9 reads 0x00 (compare depth 00), and the target is zero.
- R2: A falling edge on `rd_n` loads the byte selected by `rd_addr` into `dout`. The load happens within three clocks. `dout` then holds that byte, whatever the position does, until the next falling edge.
- R3: Read address 0 returns position bits 7:0. Read address 1 returns position bits 15:8.
- R4: A write to address 0 sets target bits 7:0, and a write to address 1 sets target bits 15:8. These writes do not change what addresses 0 and 1 read back: the reads still return the position.
- R5: Compare depth is field bits 1:0 at address 9. Depth 00 compares only position bits 7:0 with the target. Any nonzero depth compares all 16 bits.
- R6: When bit 1 of address 11 is set, `evt_n` goes low for exactly one clock when the compared bits become equal to the target. It does not go low again while they stay equal. It does not go low for a position that does not match.
- R7: When bit 0 of address 11 is set, any change of the position pulses `evt_n` low one clock after the change. An unchanged position gives no pulse. With bits 0 and 1 both clear, `evt_n` stays high.
- R8: Address 9 reads back written bits 1:0, and address 11 reads back written bits 2:0. All other bits of these two registers read as zero.
- R9: With `evt_n` tied to `rd_n` and read address 0 selected, a change of the position appears on `dout` by itself, with no host strobe.
- R10: Read addresses that map to no register return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_in | input | 16 | Interpolation position from the counter |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_n | input | 1 | Active-low read strobe, acted on at its falling edge |
| rd_addr | input | 4 | Read address |
| dout | output | 8 | Output data bus |
| evt_n | output | 1 | Active-low one-clock event pulse |

## Verification
Some properties are checked on every cycle:
- no event fires while both enables are clear;
- a compare-only event always coincides with a fresh transition into equality;
- `dout` never moves without a detected strobe fall;
- the target is zero after reset;
- an enable write lands exactly.

Other behaviour only the bench scenarios show. This covers which bytes the depth setting really compares, the byte order of the readout, that target writes leave the readback unchanged, the masking of unused bits, and the self-timed loop from event output to read strobe.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  localparam int ADDR_W     = 4;
  localparam int DEPTH_BITS = 2;
  localparam int ENA_BITS   = 3;
  localparam int ENA_VC     = 0;
  localparam int ENA_CMP    = 1;
  localparam int ENA_MAXF   = 2;
  localparam logic [ADDR_W-1:0]   CFG_ADDR  = 4'd9;
  localparam logic [ADDR_W-1:0]   ENA_ADDR  = 4'd11;
  localparam logic [ENA_BITS-1:0] ENA_RESET = 3'b101;
endpackage

// File: rtl/ptu_regs.sv
module ptu_regs
  import ptu_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [7:0]            wdata,
  output logic [POS_W-1:0]      tgt,
  output logic [DEPTH_BITS-1:0] depth,
  output logic [ENA_BITS-1:0]   ena
);
  localparam int NBYTES = POS_W / 8;

  // target bytes share the low addresses with the position readout
  for (genvar i = 0; i < NBYTES; i++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst)
        tgt[i*8 +: 8] <= '0;
      else if (we && waddr == ADDR_W'(i))
        tgt[i*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      ena   <= ENA_RESET;
    end else if (we) begin
      if (waddr == CFG_ADDR) depth <= wdata[DEPTH_BITS-1:0];
      if (waddr == ENA_ADDR) ena   <= wdata[ENA_BITS-1:0];
    end
  end

  AST_TGT_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tgt == '0));  // R1
  AST_ENA_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(waddr) == ENA_ADDR && !$past(rst))
      |-> (ena == $past(wdata[ENA_BITS-1:0])));  // R8
endmodule

// File: rtl/ptu_event.sv
module ptu_event
  import ptu_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [POS_W-1:0]      pos_in,
  input  logic [POS_W-1:0]      tgt,
  input  logic [DEPTH_BITS-1:0] depth,
  input  logic [ENA_BITS-1:0]   ena,
  output logic [POS_W-1:0]      pos_q,
  output logic                  evt_n
);
  localparam int NBYTES = POS_W / 8;

  logic [NBYTES-1:0] byte_eq;
  logic [NBYTES-1:0] byte_used;
  logic              match_now;
  logic              match_q;
  logic              changed;

  // depth d compares bytes 0..d; byte 0 always takes part
  for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
    assign byte_eq[i]   = (pos_in[i*8 +: 8] == tgt[i*8 +: 8]);
    assign byte_used[i] = (i <= int'(depth));
  end

  assign match_now = &(byte_eq | ~byte_used);
  assign changed   = (pos_in != pos_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      match_q <= 1'b0;
      evt_n   <= 1'b1;
    end else begin
      pos_q   <= pos_in;
      match_q <= match_now;
      evt_n   <= ~((ena[ENA_VC] & changed) |
                   (ena[ENA_CMP] & match_now & ~match_q));
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(ena[ENA_VC]) && !$past(ena[ENA_CMP])) |-> evt_n);  // R7
  AST_MATCH_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!evt_n && !$past(ena[ENA_VC])) |-> (match_q && !$past(match_q)));  // R6
endmodule

// File: rtl/ptu_readout.sv
module ptu_readout
  import ptu_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_n,
  input  logic [ADDR_W-1:0]     raddr,
  input  logic [POS_W-1:0]      pos_q,
  input  logic [DEPTH_BITS-1:0] depth,
  input  logic [ENA_BITS-1:0]   ena,
  output logic [7:0]            dout
);
  localparam int NBYTES = POS_W / 8;

  logic       s1, s2, s3;
  logic       fall;
  logic [7:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rd_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;

  always_comb begin
    sel = 8'h00;
    for (int i = 0; i < NBYTES; i++)
      if (raddr == ADDR_W'(i)) sel = pos_q[i*8 +: 8];
    if (raddr == CFG_ADDR) sel = 8'({depth});
    if (raddr == ENA_ADDR) sel = 8'({ena});
  end

  always_ff @(posedge clk) begin
    if (rst)
      dout <= 8'h00;
    else if (fall)
      dout <= sel;
  end

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(fall) |-> $stable(dout));  // R2
endmodule

// File: rtl/pos_trig_unit.sv
module pos_trig_unit
  import ptu_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos_in,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_n,
  input  logic [3:0]       rd_addr,
  output logic [7:0]       dout,
  output logic             evt_n
);
  logic [POS_W-1:0]      tgt;
  logic [POS_W-1:0]      pos_q;
  logic [DEPTH_BITS-1:0] depth;
  logic [ENA_BITS-1:0]   ena;

  ptu_regs #(.POS_W(POS_W)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .tgt(tgt), .depth(depth), .ena(ena)
  );

  ptu_event #(.POS_W(POS_W)) u_event (
    .clk(clk), .rst(rst), .pos_in(pos_in), .tgt(tgt), .depth(depth),
    .ena(ena), .pos_q(pos_q), .evt_n(evt_n)
  );

  ptu_readout #(.POS_W(POS_W)) u_readout (
    .clk(clk), .rst(rst), .rd_n(rd_n), .raddr(rd_addr), .pos_q(pos_q),
    .depth(depth), .ena(ena), .dout(dout)
  );
endmodule

// File: tb/tb_pos_trig_unit.sv
`timescale 1ns/1ps
module tb_pos_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pos_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_drv = 1'b1;
  logic        loop = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  dout;
  logic        evt_n;
  logic        rd_n;
  int total = 0;
  int bad = 0;

  assign rd_n = loop ? evt_n : rd_drv;

  always #2.5 clk = ~clk;

  pos_trig_unit dut (
    .clk(clk), .rst(rst), .pos_in(pos_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_n(rd_n), .rd_addr(rd_addr), .dout(dout), .evt_n(evt_n)
  );

  typedef struct packed {
    logic [1:0]  d;
    logic [15:0] p;
    logic        e;
  } vec_t;

  // target 0x1234, compare enable only; e = pulse expected
  localparam vec_t VEC [12] = '{
    '{2'd0, 16'h0010, 1'b0}, '{2'd0, 16'h0034, 1'b1}, '{2'd0, 16'h0034, 1'b0},
    '{2'd0, 16'h1234, 1'b0}, '{2'd0, 16'h1235, 1'b0}, '{2'd0, 16'h5634, 1'b1},
    '{2'd0, 16'h0000, 1'b0}, '{2'd1, 16'h0034, 1'b0}, '{2'd1, 16'h1234, 1'b1},
    '{2'd1, 16'h1334, 1'b0}, '{2'd1, 16'h1234, 1'b1}, '{2'd1, 16'h1234, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a; rd_drv = 1'b0;
    repeat (4) @(negedge clk);
    v = dout;
    rd_drv = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [1:0] cur_d;
    repeat (4) @(negedge clk);
    chk("R1 dout in reset", 16'(dout), 16'h00);
    chk("R1 evt_n in reset", 16'(evt_n), 16'h1);
    rst = 1'b0;
    @(negedge clk);
    rd(4'd11, v); chk("R1 enable preset", 16'(v), 16'h05);
    rd(4'd9, v);  chk("R1 depth preset", 16'(v), 16'h00);
    rd(4'd0, v);  chk("R3 low byte at zero", 16'(v), 16'h00);

    pos_in = 16'hBEEF;
    repeat (2) @(negedge clk);
    rd(4'd0, v); chk("R3 low byte", 16'(v), 16'hEF);
    rd(4'd1, v); chk("R3 high byte", 16'(v), 16'hBE);
    pos_in = 16'h1111;
    repeat (5) @(negedge clk);
    chk("R2 dout held without strobe", 16'(dout), 16'hBE);
    rd(4'd5, v); chk("R10 unmapped read", 16'(v), 16'h00);

    wr(4'd9, 8'hFF);  rd(4'd9, v);  chk("R8 depth readback", 16'(v), 16'h03);
    wr(4'd11, 8'hFF); rd(4'd11, v); chk("R8 enable readback", 16'(v), 16'h07);

    wr(4'd9, 8'h00);
    wr(4'd11, 8'h01);
    @(negedge clk);
    pos_in = 16'h0101;
    @(negedge clk); chk("R7 change pulse low", 16'(evt_n), 16'h0);
    @(negedge clk); chk("R7 pulse one clock", 16'(evt_n), 16'h1);
    pos_in = 16'h0101;
    @(negedge clk); chk("R7 no pulse on same value", 16'(evt_n), 16'h1);
    wr(4'd11, 8'h00);
    pos_in = 16'h0202;
    @(negedge clk); chk("R7 no pulse when disabled", 16'(evt_n), 16'h1);
    @(negedge clk); chk("R7 still high when disabled", 16'(evt_n), 16'h1);

    pos_in = 16'h0000;
    @(negedge clk);
    wr(4'd11, 8'h02);
    wr(4'd0, 8'h34);
    wr(4'd1, 8'h12);
    rd(4'd0, v); chk("R4 addr0 still reads position", 16'(v), 16'h00);
    rd(4'd1, v); chk("R4 addr1 still reads position", 16'(v), 16'h00);

    cur_d = 2'd0;
    foreach (VEC[i]) begin
      if (VEC[i].d != cur_d) begin
        wr(4'd9, 8'(VEC[i].d));
        cur_d = VEC[i].d;
      end
      pos_in = VEC[i].p;
      @(negedge clk);
      chk($sformatf("R5 R6 vector %0d", i), 16'(evt_n), 16'(!VEC[i].e));
    end

    wr(4'd9, 8'h00);
    wr(4'd11, 8'h05);
    rd_addr = 4'd0;
    loop = 1'b1;
    @(negedge clk);
    pos_in = 16'h00A7;
    repeat (8) @(negedge clk);
    chk("R9 self-timed readout", 16'(dout), 16'hA7);
    pos_in = 16'h00C3;
    repeat (8) @(negedge clk);
    chk("R9 second self-timed readout", 16'(dout), 16'hC3);
    loop = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule